// File: doc/BRIEF.md
# Per-Port SPI Clock and Chip-Select Timing Engine

This block is the timing core of a SPI master that serves five chip-select ports. Each port has its own packed timing word (bit-rate code, select setup, select hold, minimum deselect time) and its own clock polarity, clock phase, select idle level and data idle level. The idle and mode bits sit in one shared state word, packed in reversed port order. A port-select field in the same word chooses which port the next transaction uses.

A sequencer raises `start_i` to open a transaction. It holds `last_i` high during the final byte and may set `gap_en_i` to stretch the space between bytes. The engine asserts the chip select, waits out the setup time and toggles SCLK at the programmed rate. It emits one strobe per SCLK edge, telling the shifter to launch or to capture a bit. It then applies the hold time and keeps the select inactive for the programmed minimum time before it will accept another start. While idle, the select, clock and data-idle outputs follow the currently selected port.

Top module: `spi_port_timing`

## Requirements
- R1: Port p's timing word lies at bits [32p+31:32p] of `port_param_i`. Within the word, the rate code is in 31:24, setup S in 23:16, hold H in 15:8 and minimum deselect D in 7:0. Only the selected port's word affects a transaction.
- R2: A rate code r gives a half bit period HALF = 128 / 2^k clock cycles, where k is the highest set bit of r (r = 0 behaves like r = 1). Each byte consists of 16 SCLK transitions spaced HALF cycles apart.
- R3: The port select is `port_state_i[22:20]`. Bits 19:15 hold clock idle, 14:10 clock phase, 9:5 select idle and 4:0 data idle, each as one bit per port, with port p at bit (group base + 4 − p). While idle, `cs_o`, `sclk_o` and `dat_idle_o` show the selected port's bits. During a transaction, `dat_idle_o` holds the latched port's data idle bit.
- R4: A port select of 5, 6 or 7 refuses `start_i` and drives `cs_o`=1, `sclk_o`=0 and `dat_idle_o`=0.
- R5: `start_i` is accepted only while `busy_o` is low. On the cycle after acceptance, `busy_o` is 1 and `cs_o` is the inverse of the port's select idle bit.
- R6: The first SCLK transition comes S + HALF cycles after `cs_o` goes active.
- R7: SCLK rests at the clock idle bit. Mode code {idle, phase}: mode 1 sets phase, mode 2 sets idle high, mode 3 sets both. Each transition carries exactly one strobe, in the same cycle. With phase 0, odd-numbered transitions carry `sample_o` and even-numbered ones carry `shift_o`; with phase 1 this is reversed. No strobe appears without a transition.
- R8: `last_i` is sampled at the 16th transition of each byte. If it is high, `cs_o` goes inactive H cycles after that transition.
- R9: Between bytes, the first transition of the next byte follows the last transition of the previous byte by HALF cycles, or by HALF + H when `gap_en_i` is high. A final byte gets no gap.
- R10: `busy_o` stays high for D cycles after `cs_o` goes inactive. A start held continuously therefore sees `cs_o` inactive for D + 1 cycles.
- R11: During and after reset, `busy_o`, `shift_o` and `sample_o` are 0, and the idle outputs follow the selected port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_param_i | input | 160 | Five packed per-port timing words |
| port_state_i | input | 23 | Port select and reversed per-port mode/idle bits |
| start_i | input | 1 | Transaction request |
| last_i | input | 1 | Current byte is the final one |
| gap_en_i | input | 1 | Insert a hold-length gap between bytes |
| busy_o | output | 1 | Transaction or deselect window in progress |
| cs_o | output | 1 | Chip-select line level |
| sclk_o | output | 1 | Serial clock level |
| dat_idle_o | output | 1 | Level the data line should rest at |
| shift_o | output | 1 | Launch-edge strobe |
| sample_o | output | 1 | Capture-edge strobe |

## Verification
The byte-end decision is the point where two functions meet at one edge. If `last_i` and `gap_en_i` are both high at the 16th transition, the hold must win, with no gap added before it. One vector drives that combination, and the bench measures the distance from the last transition to deselect, which must equal H rather than 2H. The deselect window and a continuously held start also meet in the cycle where the window closes. A directed test holds `start_i` high throughout and requires the select to stay inactive for exactly D + 1 cycles.

// File: rtl/spi_tm_pkg.sv
package spi_tm_pkg;

    localparam int FIELD_W = 8;
    localparam int WORD_W  = 4 * FIELD_W;
    localparam logic [FIELD_W-1:0] RATE_TOP = FIELD_W'(1 << (FIELD_W - 1));

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_RUN,
        ST_GAP,
        ST_HOLD,
        ST_REST
    } tm_state_e;

    typedef struct packed {
        logic cpol;
        logic cpha;
        logic csi;
        logic di;
    } line_cfg_t;

    typedef struct packed {
        logic [FIELD_W-1:0] half;
        logic [FIELD_W-1:0] setup;
        logic [FIELD_W-1:0] hold;
        logic [FIELD_W-1:0] dly;
        line_cfg_t          lines;
    } port_cfg_t;

    // Highest set bit of the rate code picks the half period; zero is slowest.
    function automatic logic [FIELD_W-1:0] half_from_rate(input logic [FIELD_W-1:0] r);
        logic [FIELD_W-1:0] h;
        h = RATE_TOP;
        for (int i = 0; i < FIELD_W; i++)
            if (r[i]) h = RATE_TOP >> i;
        return h;
    endfunction

endpackage

// File: rtl/spi_tm_cfg_sel.sv
module spi_tm_cfg_sel
    import spi_tm_pkg::*;
#(
    parameter  int NPORTS  = 5,
    localparam int SEL_W   = $clog2(NPORTS),
    localparam int STATE_W = 4 * NPORTS + SEL_W
) (
    input  logic [NPORTS*WORD_W-1:0] param_words_i,
    input  logic [STATE_W-1:0]       state_word_i,
    output port_cfg_t                cfg_o,
    output logic                     sel_ok_o
);
    localparam int DI_BASE   = 0;
    localparam int CSI_BASE  = NPORTS;
    localparam int CPHA_BASE = 2 * NPORTS;
    localparam int CPOL_BASE = 3 * NPORTS;
    localparam int SEL_LSB   = 4 * NPORTS;

    port_cfg_t        cfg_arr [NPORTS];
    logic [SEL_W-1:0] sel;

    assign sel = state_word_i[SEL_LSB +: SEL_W];

    generate
        for (genvar p = 0; p < NPORTS; p++) begin : g_port
            localparam int OFS = p * WORD_W;
            localparam int REV = NPORTS - 1 - p;
            assign cfg_arr[p] = '{
                half:  half_from_rate(param_words_i[OFS + 3*FIELD_W +: FIELD_W]),
                setup: param_words_i[OFS + 2*FIELD_W +: FIELD_W],
                hold:  param_words_i[OFS + FIELD_W +: FIELD_W],
                dly:   param_words_i[OFS +: FIELD_W],
                lines: '{cpol: state_word_i[CPOL_BASE + REV],
                         cpha: state_word_i[CPHA_BASE + REV],
                         csi:  state_word_i[CSI_BASE + REV],
                         di:   state_word_i[DI_BASE + REV]}
            };
        end
    endgenerate

    always_comb begin
        cfg_o    = '0;
        sel_ok_o = 1'b0;
        for (int p = 0; p < NPORTS; p++) begin
            if (sel == SEL_W'(p)) begin
                cfg_o    = cfg_arr[p];
                sel_ok_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/spi_tm_engine.sv
module spi_tm_engine
    import spi_tm_pkg::*;
#(
    parameter  int FRAME_BITS = 8,
    localparam int EDGES      = 2 * FRAME_BITS,
    localparam int EW         = $clog2(EDGES)
) (
    input  logic      clk,
    input  logic      rst,
    input  port_cfg_t cfg_i,
    input  logic      sel_ok_i,
    input  logic      start_i,
    input  logic      last_i,
    input  logic      gap_en_i,
    output logic      busy_o,
    output logic      rest_o,
    output logic      tog_o,
    output logic      lead_o,
    output logic      trail_o,
    output line_cfg_t lines_q_o
);
    localparam logic [EW-1:0]      ELAST = EW'(EDGES - 1);
    localparam logic [FIELD_W-1:0] ONE   = FIELD_W'(1);

    tm_state_e          st;
    logic [FIELD_W-1:0] cnt, half_q, hold_q, dly_q;
    logic [EW-1:0]      ecnt;
    line_cfg_t          lines_q;
    logic               tog, lead_q, trail_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            cnt     <= '0;
            ecnt    <= '0;
            half_q  <= '0;
            hold_q  <= '0;
            dly_q   <= '0;
            lines_q <= '0;
            tog     <= 1'b0;
            lead_q  <= 1'b0;
            trail_q <= 1'b0;
        end else begin
            lead_q  <= 1'b0;
            trail_q <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (start_i && sel_ok_i) begin
                        half_q  <= cfg_i.half;
                        hold_q  <= cfg_i.hold;
                        dly_q   <= cfg_i.dly;
                        lines_q <= cfg_i.lines;
                        tog     <= 1'b0;
                        ecnt    <= '0;
                        if (cfg_i.setup == '0) begin
                            st  <= ST_RUN;
                            cnt <= cfg_i.half - ONE;
                        end else begin
                            st  <= ST_SETUP;
                            cnt <= cfg_i.setup - ONE;
                        end
                    end
                end
                ST_SETUP, ST_GAP: begin
                    if (cnt == '0) begin
                        st  <= ST_RUN;
                        cnt <= half_q - ONE;
                    end else begin
                        cnt <= cnt - ONE;
                    end
                end
                ST_RUN: begin
                    if (cnt != '0) begin
                        cnt <= cnt - ONE;
                    end else begin
                        tog     <= ~tog;
                        lead_q  <= ~ecnt[0];
                        trail_q <= ecnt[0];
                        cnt     <= half_q - ONE;
                        if (ecnt == ELAST) begin
                            ecnt <= '0;
                            if (last_i) begin
                                if (hold_q != '0) begin
                                    st  <= ST_HOLD;
                                    cnt <= hold_q - ONE;
                                end else if (dly_q != '0) begin
                                    st  <= ST_REST;
                                    cnt <= dly_q - ONE;
                                end else begin
                                    st  <= ST_IDLE;
                                end
                            end else if (gap_en_i && hold_q != '0) begin
                                st  <= ST_GAP;
                                cnt <= hold_q - ONE;
                            end
                        end else begin
                            ecnt <= ecnt + EW'(1);
                        end
                    end
                end
                ST_HOLD: begin
                    if (cnt != '0) begin
                        cnt <= cnt - ONE;
                    end else if (dly_q != '0) begin
                        st  <= ST_REST;
                        cnt <= dly_q - ONE;
                    end else begin
                        st  <= ST_IDLE;
                    end
                end
                ST_REST: begin
                    if (cnt == '0) st <= ST_IDLE;
                    else           cnt <= cnt - ONE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy_o    = (st != ST_IDLE);
    assign rest_o    = (st == ST_REST);
    assign tog_o     = tog;
    assign lead_o    = lead_q;
    assign trail_o   = trail_q;
    assign lines_q_o = lines_q;

endmodule

// File: rtl/spi_tm_pins.sv
module spi_tm_pins
    import spi_tm_pkg::*;
(
    input  logic      busy_i,
    input  logic      rest_i,
    input  logic      tog_i,
    input  logic      lead_i,
    input  logic      trail_i,
    input  line_cfg_t lines_q_i,
    input  logic      sel_ok_i,
    input  logic      sel_csi_i,
    input  logic      sel_cpol_i,
    input  logic      sel_di_i,
    output logic      cs_o,
    output logic      sclk_o,
    output logic      dat_o,
    output logic      shift_o,
    output logic      sample_o
);
    always_comb begin
        if (!busy_i) begin
            cs_o   = sel_ok_i ? sel_csi_i : 1'b1;
            sclk_o = sel_ok_i & sel_cpol_i;
            dat_o  = sel_ok_i & sel_di_i;
        end else begin
            cs_o   = rest_i ? lines_q_i.csi : ~lines_q_i.csi;
            sclk_o = lines_q_i.cpol ^ tog_i;
            dat_o  = lines_q_i.di;
        end
        shift_o  = lines_q_i.cpha ? lead_i  : trail_i;
        sample_o = lines_q_i.cpha ? trail_i : lead_i;
    end

endmodule

// File: rtl/spi_port_timing.sv
module spi_port_timing
    import spi_tm_pkg::*;
#(
    parameter  int NPORTS     = 5,
    parameter  int FRAME_BITS = 8,
    localparam int SEL_W      = $clog2(NPORTS),
    localparam int STATE_W    = 4 * NPORTS + SEL_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NPORTS*WORD_W-1:0] port_param_i,
    input  logic [STATE_W-1:0]       port_state_i,
    input  logic                     start_i,
    input  logic                     last_i,
    input  logic                     gap_en_i,
    output logic                     busy_o,
    output logic                     cs_o,
    output logic                     sclk_o,
    output logic                     dat_idle_o,
    output logic                     shift_o,
    output logic                     sample_o
);
    port_cfg_t cfg_sel;
    line_cfg_t lines_q;
    logic      sel_ok, rest, tog, lead, trail;

    spi_tm_cfg_sel #(.NPORTS(NPORTS)) u_sel (
        .param_words_i (port_param_i),
        .state_word_i  (port_state_i),
        .cfg_o         (cfg_sel),
        .sel_ok_o      (sel_ok)
    );

    spi_tm_engine #(.FRAME_BITS(FRAME_BITS)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .cfg_i     (cfg_sel),
        .sel_ok_i  (sel_ok),
        .start_i   (start_i),
        .last_i    (last_i),
        .gap_en_i  (gap_en_i),
        .busy_o    (busy_o),
        .rest_o    (rest),
        .tog_o     (tog),
        .lead_o    (lead),
        .trail_o   (trail),
        .lines_q_o (lines_q)
    );

    spi_tm_pins u_pins (
        .busy_i     (busy_o),
        .rest_i     (rest),
        .tog_i      (tog),
        .lead_i     (lead),
        .trail_i    (trail),
        .lines_q_i  (lines_q),
        .sel_ok_i   (sel_ok),
        .sel_csi_i  (cfg_sel.lines.csi),
        .sel_cpol_i (cfg_sel.lines.cpol),
        .sel_di_i   (cfg_sel.lines.di),
        .cs_o       (cs_o),
        .sclk_o     (sclk_o),
        .dat_o      (dat_idle_o),
        .shift_o    (shift_o),
        .sample_o   (sample_o)
    );

endmodule

// File: rtl/spi_port_timing_chk.sv
module spi_port_timing_chk #(
    parameter int NPORTS = 5,
    parameter int SEL_W  = 3
) (
    input logic             clk,
    input logic             rst,
    input logic [SEL_W-1:0] sel_i,
    input logic             start_i,
    input logic             busy_o,
    input logic             cs_o,
    input logic             sclk_o,
    input logic             shift_o,
    input logic             sample_o
);
    AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(shift_o && sample_o)); // R7

    AST_STROBE_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        (shift_o || sample_o) |-> (sclk_o != $past(sclk_o))); // R7

    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !$past(busy_o)) |-> (!shift_o && !sample_o)); // R11

    AST_CS_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> (cs_o != $past(cs_o))); // R5

    AST_BAD_PORT_REFUSED: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i && sel_i >= SEL_W'(NPORTS)) |=> !busy_o); // R4

endmodule

bind spi_port_timing spi_port_timing_chk #(.NPORTS(NPORTS), .SEL_W(SEL_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sel_i    (port_state_i[4*NPORTS +: SEL_W]),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .cs_o     (cs_o),
    .sclk_o   (sclk_o),
    .shift_o  (shift_o),
    .sample_o (sample_o)
);

// File: tb/spi_port_timing_tb.sv
module spi_port_timing_tb_top;

    localparam int NP      = 5;
    localparam int STATE_W = 23;

    typedef struct packed {
        logic [7:0] rate;
        logic [7:0] setup;
        logic [7:0] hold;
        logic [7:0] dly;
        logic [1:0] mode;
        logic       csi;
        logic       di;
        logic [2:0] port;
        logic [2:0] nbytes;
        logic       gap;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{8'd128, 8'd0, 8'd0, 8'd0, 2'd0, 1'b1, 1'b0, 3'd0, 3'd1, 1'b0},
        '{8'd64,  8'd3, 8'd2, 8'd4, 2'd1, 1'b1, 1'b1, 3'd1, 3'd2, 1'b0},
        '{8'd32,  8'd1, 8'd3, 8'd2, 2'd2, 1'b0, 1'b0, 3'd2, 3'd2, 1'b1},
        '{8'd128, 8'd5, 8'd1, 8'd0, 2'd3, 1'b1, 1'b1, 3'd3, 3'd3, 1'b1},
        '{8'd64,  8'd0, 8'd4, 8'd1, 2'd0, 1'b0, 1'b1, 3'd4, 3'd2, 1'b1},
        '{8'd1,   8'd2, 8'd0, 8'd3, 2'd1, 1'b1, 1'b0, 3'd0, 3'd1, 1'b0},
        '{8'd3,   8'd0, 8'd1, 8'd1, 2'd2, 1'b1, 1'b0, 3'd2, 3'd1, 1'b0}
    };

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [NP*32-1:0]     port_param = '0;
    logic [STATE_W-1:0]   port_state = '0;
    logic                 start = 1'b0, last = 1'b0, gap_en = 1'b0;
    logic                 busy_o, cs_o, sclk_o, dat_idle_o, shift_o, sample_o;
    int                   checks = 0, fails = 0, cyc = 0;

    always #10 clk = ~clk;

    spi_port_timing dut_i (
        .clk(clk), .rst(rst), .port_param_i(port_param), .port_state_i(port_state),
        .start_i(start), .last_i(last), .gap_en_i(gap_en),
        .busy_o(busy_o), .cs_o(cs_o), .sclk_o(sclk_o), .dat_idle_o(dat_idle_o),
        .shift_o(shift_o), .sample_o(sample_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            checks = checks + 1;
            fails  = fails + 1;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic int half_of(input logic [7:0] r);
        for (int i = 7; i >= 0; i--)
            if (r[i]) return 128 >> i;
        return 128;
    endfunction

    // R1 word packing, R3 reversed group bits; other ports get contrasting values
    task automatic build_cfg(input vec_t v);
        for (int p = 0; p < NP; p++) begin
            if (p == int'(v.port)) port_param[p*32 +: 32] = {v.rate, v.setup, v.hold, v.dly};
            else                   port_param[p*32 +: 32] = {8'd128, 8'd9, 8'd9, 8'd9};
            port_state[15 + 4 - p] = (p == int'(v.port)) ? v.mode[1] : ~v.mode[1];
            port_state[10 + 4 - p] = (p == int'(v.port)) ? v.mode[0] : ~v.mode[0];
            port_state[5 + 4 - p]  = (p == int'(v.port)) ? v.csi : ~v.csi;
            port_state[0 + 4 - p]  = (p == int'(v.port)) ? v.di : ~v.di;
        end
        port_state[22:20] = v.port;
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        int  half, t, t_on, t_first, t_last, t_off, t_free, edges, prev_t;
        int  intra_bad, bound_bad, stb_bad, dat_bad, exp_iv;
        bit  on, off, prev_s, cpol, cpha, exp_samp;
        half = half_of(v.rate);
        cpol = v.mode[1];
        cpha = v.mode[0];
        t = 0; t_on = 0; t_first = 0; t_last = 0; t_off = 0; t_free = 0; edges = 0; prev_t = 0;
        intra_bad = 0; bound_bad = 0; stb_bad = 0; dat_bad = 0; on = 0; off = 0;
        @(negedge clk);
        build_cfg(v);
        gap_en = v.gap;
        last   = (v.nbytes == 3'd1);
        start  = 1'b0;
        @(negedge clk);
        chk(cs_o == v.csi && sclk_o == cpol && dat_idle_o == v.di && !busy_o,
            $sformatf("R3 vec%0d idle levels {cs,sclk,dat}", idx),
            {cs_o, sclk_o, dat_idle_o}, {v.csi, cpol, v.di});
        start  = 1'b1;
        prev_s = sclk_o;
        while (1) begin
            @(negedge clk);
            t++;
            if (t == 1) start = 1'b0;
            if (!on && cs_o != v.csi) begin on = 1; t_on = t; end
            if (sclk_o != prev_s) begin
                edges++;
                if (edges == 1) t_first = t;
                else begin
                    exp_iv = ((edges - 1) % 16 == 0) ? half + (v.gap ? int'(v.hold) : 0) : half;
                    if (t - prev_t != exp_iv) begin
                        if ((edges - 1) % 16 == 0) bound_bad++;
                        else intra_bad++;
                    end
                end
                prev_t   = t;
                t_last   = t;
                exp_samp = ((edges % 2) == 1) != cpha;
                if (sample_o != exp_samp || shift_o != !exp_samp) stb_bad++;
                prev_s = sclk_o;
            end else if (shift_o || sample_o) stb_bad++;
            if (dat_idle_o != v.di) dat_bad++;
            if (edges >= 16 * (int'(v.nbytes) - 1)) last = 1'b1;
            if (on && !off && cs_o == v.csi) begin off = 1; t_off = t; end
            if (off && !busy_o) begin t_free = t; break; end
            if (t > 30000) break;
        end
        chk(on && off, $sformatf("R5 vec%0d select activity seen", idx), int'(on) + int'(off), 2);
        chk(t_first - t_on == int'(v.setup) + half, $sformatf("R6 vec%0d setup to first edge", idx),
            t_first - t_on, int'(v.setup) + half);
        chk(edges == 16 * int'(v.nbytes), $sformatf("R2 vec%0d transition count", idx), edges, 16 * int'(v.nbytes));
        chk(intra_bad == 0, $sformatf("R2 vec%0d half-period spacing errors", idx), intra_bad, 0);
        chk(bound_bad == 0, $sformatf("R9 vec%0d byte boundary spacing errors", idx), bound_bad, 0);
        chk(stb_bad == 0, $sformatf("R7 vec%0d strobe errors", idx), stb_bad, 0);
        chk(t_off - t_last == int'(v.hold), $sformatf("R8 vec%0d hold after last edge", idx),
            t_off - t_last, int'(v.hold));
        chk(t_free - t_off == int'(v.dly), $sformatf("R10 vec%0d busy tail after deselect", idx),
            t_free - t_off, int'(v.dly));
        chk(sclk_o == cpol, $sformatf("R7 vec%0d clock rests at idle", idx), sclk_o, cpol);
        chk(dat_bad == 0, $sformatf("R3 vec%0d data idle held", idx), dat_bad, 0);
        last = 1'b0;
    endtask

    initial begin
        vec_t vh;
        int   n;
        bit   ok;
        // R11: reset state, port 0 with clock idle, select idle and data idle high
        port_state[19] = 1'b1;
        port_state[9]  = 1'b1;
        port_state[4]  = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy_o && !shift_o && !sample_o, "R11 quiet in reset", {busy_o, shift_o, sample_o}, 0);
        chk(cs_o && sclk_o && dat_idle_o, "R11 idle levels in reset", {cs_o, sclk_o, dat_idle_o}, 7);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy_o && cs_o && sclk_o && dat_idle_o, "R11 after reset", {busy_o, cs_o, sclk_o, dat_idle_o}, 7);

        // R3: reversed bit order for port 3 (bits 16, 6, 1)
        port_state = '0;
        port_state[16] = 1'b1; port_state[6] = 1'b1; port_state[1] = 1'b1;
        port_state[22:20] = 3'd3;
        @(negedge clk);
        chk(cs_o && sclk_o && dat_idle_o, "R3 port3 reversed bits", {cs_o, sclk_o, dat_idle_o}, 7);
        port_state[22:20] = 3'd1;
        @(negedge clk);
        chk(!cs_o && !sclk_o && !dat_idle_o, "R3 port1 ignores port3 bits", {cs_o, sclk_o, dat_idle_o}, 0);

        // table walk
        for (int i = 0; i < 7; i++) run_vec(VECS[i], i);

        // R4: out-of-range port selects
        for (int s = 5; s < 8; s++) begin
            @(negedge clk);
            port_state = '1;
            port_state[22:20] = 3'(s);
            start = 1'b1;
            ok = 1;
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                if (busy_o || !cs_o || sclk_o || dat_idle_o) ok = 0;
            end
            start = 1'b0;
            chk(ok, $sformatf("R4 select %0d refused", s), {busy_o, cs_o, sclk_o, dat_idle_o}, 4);
        end

        // R10: held start sees D+1 inactive cycles
        vh = '{8'd128, 8'd0, 8'd1, 8'd3, 2'd0, 1'b1, 1'b0, 3'd2, 3'd1, 1'b0};
        @(negedge clk);
        build_cfg(vh);
        last = 1'b1; gap_en = 1'b0; start = 1'b1;
        n = 0;
        while (cs_o == 1'b1 && n < 1000) begin @(negedge clk); n++; end
        while (cs_o == 1'b0 && n < 1000) begin @(negedge clk); n++; end
        n = 1;
        while (1) begin
            @(negedge clk);
            if (cs_o == 1'b0 || n > 1000) break;
            n++;
        end
        start = 1'b0;
        chk(n == 4, "R10 held start inactive window", n, 4);
        n = 0;
        while (busy_o && n < 1000) begin @(negedge clk); n++; end
        chk(!busy_o && cs_o, "R5 engine returns to idle", {busy_o, cs_o}, 1);
        last = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule